// File: doc/BRIEF.md
# Programmable CRT Timing Generator

This block produces the raster timing of a character-based display. One clock cycle is one character time. A horizontal character counter and a vertical line counter run freely. The block compares them against a bank of programming registers and derives display-enable, blanking, horizontal sync and vertical sync from those comparisons. Each output region opens when its counter equals a start value. It closes when the low bits of the counter equal a short end field, so a region may run across the counter wrap.

Software programs the bank through a three-address write port. One address loads an index pointer. One address writes the register the pointer selects. One address sets the two sync polarity bits. The block also returns a status byte that shows both retrace states and a vertical-retrace interrupt flag, and it drives an interrupt line from that flag.

Top module: `crtg_timing`

## Requirements
- R1: The character counter counts 0, 1, 2, … and returns to 0 after the value (index 0) + 4. A line therefore lasts (index 0) + 5 characters.
- R2: `disp_en_o` is high exactly when the character counter is at or below index 1 and the line counter is at or below the 10-bit vertical display end. That value takes bits 7:0 from index 18, bit 8 from index 7 bit 1 and bit 9 from index 7 bit 6.
- R3: Horizontal blanking begins at the character equal to index 2. It stays active until the low 6 bits of the counter equal the 6-bit end value, and ends at that character. The end value takes bits 4:0 from index 3 bits 4:0 and bit 5 from index 5 bit 7.
- R4: Horizontal retrace begins at the character equal to index 4. It ends at the character whose low 5 bits equal index 5 bits 4:0.
- R5: The line counter advances once per character-counter wrap. It returns to 0 after the 10-bit vertical total + 1, so a frame lasts vertical total + 2 lines. The vertical total takes bits 7:0 from index 6, bit 8 from index 7 bit 0 and bit 9 from index 7 bit 5.
- R6: Vertical blanking begins on the line equal to the 10-bit blank start and ends on the line whose low 8 bits equal index 22. The blank start takes bits 7:0 from index 21, bit 8 from index 7 bit 3 and bit 9 from index 9 bit 5.
- R7: Vertical retrace begins on the line equal to the 10-bit retrace start and ends on the line whose low 4 bits equal index 17 bits 3:0. The retrace start takes bits 7:0 from index 16, bit 8 from index 7 bit 2 and bit 9 from index 7 bit 7.
- R8: While index 17 bit 7 is 1, data writes to indices 0 to 7 have no effect. Writes to the other indices still take effect.
- R9: When vertical retrace starts and index 17 bit 5 is 0, the interrupt flag is set. The flag is held clear while index 17 bit 4 is 0. The flag drives `irq_o`, and it is 0 after reset.
- R10: `status_o` bit 7 is the interrupt flag, bit 3 the vertical retrace state and bit 0 the horizontal retrace state. All other bits are 0.
- R11: A write with `bus_sel` = 2 stores the polarity bits. Data bit 6 inverts `hsync_o` and data bit 7 inverts `vsync_o`.
- R12: `blank_o` is the OR of horizontal and vertical blanking. `bus_sel` = 0 loads the index pointer from data bits 4:0, `bus_sel` = 1 writes the indexed register, and reset clears every register to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_sel | input | 2 | 0 index pointer, 1 indexed data, 2 polarity |
| bus_wdata | input | 8 | Write data |
| disp_en_o | output | 1 | Active display area |
| blank_o | output | 1 | Combined blanking |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| irq_o | output | 1 | Vertical retrace interrupt flag |
| status_o | output | 8 | Interrupt flag, vertical and horizontal retrace |

## Verification
The remembered blank and retrace flags carry state from one character or line to the next. If one is wrong, the output stays in the wrong level until the next start or end match, which can be up to a full line or frame later. A wrong counter limit shows as a changed retrace-to-retrace distance. The bench therefore measures these distances at the status port as well as comparing every output on every cycle. An interrupt flag that is not cleared is seen one cycle after the clear bit drops. A protected write that slips through shows as a different line length within one line.

// File: rtl/crtg_pkg.sv
package crtg_pkg;
   localparam int REG_W  = 8;
   localparam int IDX_W  = 5;
   localparam int VVAL_W = 10;
   localparam int HBE_W  = 6;
   localparam int HSE_W  = 5;
   localparam int VBE_W  = 8;
   localparam int VSE_W  = 4;
   localparam int H_ADJ  = 5;
   localparam int V_ADJ  = 2;

   localparam logic [IDX_W-1:0] IX_HTOT  = 5'd0;
   localparam logic [IDX_W-1:0] IX_HDEND = 5'd1;
   localparam logic [IDX_W-1:0] IX_HBST  = 5'd2;
   localparam logic [IDX_W-1:0] IX_HBEND = 5'd3;
   localparam logic [IDX_W-1:0] IX_HSST  = 5'd4;
   localparam logic [IDX_W-1:0] IX_HSEND = 5'd5;
   localparam logic [IDX_W-1:0] IX_VTOT  = 5'd6;
   localparam logic [IDX_W-1:0] IX_OVFL  = 5'd7;
   localparam logic [IDX_W-1:0] IX_VHIGH = 5'd9;
   localparam logic [IDX_W-1:0] IX_VSST  = 5'd16;
   localparam logic [IDX_W-1:0] IX_VSEND = 5'd17;
   localparam logic [IDX_W-1:0] IX_VDEND = 5'd18;
   localparam logic [IDX_W-1:0] IX_VBST  = 5'd21;
   localparam logic [IDX_W-1:0] IX_VBEND = 5'd22;
   localparam logic [IDX_W-1:0] PROT_LIM = 5'd8;

   typedef enum logic [1:0] {
      SEL_INDEX = 2'd0,
      SEL_DATA  = 2'd1,
      SEL_POL   = 2'd2,
      SEL_NONE  = 2'd3
   } bus_sel_e;

   typedef struct packed {
      logic [REG_W-1:0]  h_total;
      logic [REG_W-1:0]  h_de_end;
      logic [REG_W-1:0]  h_bl_st;
      logic [HBE_W-1:0]  h_bl_end;
      logic [REG_W-1:0]  h_sy_st;
      logic [HSE_W-1:0]  h_sy_end;
      logic [VVAL_W-1:0] v_total;
      logic [VVAL_W-1:0] v_de_end;
      logic [VVAL_W-1:0] v_bl_st;
      logic [VVAL_W-1:0] v_sy_st;
      logic [VBE_W-1:0]  v_bl_end;
      logic [VSE_W-1:0]  v_sy_end;
      logic              protect;
      logic              irq_off;
      logic              irq_clr_n;
   } crtg_cfg_t;
endpackage

// File: rtl/crtg_regfile.sv
module crtg_regfile
   import crtg_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       sel,
   input  logic [REG_W-1:0] wdata,
   output crtg_cfg_t        cfg,
   output logic [IDX_W-1:0] idx,
   output logic [1:0]       pol
);
   logic locked;

   always_comb locked = cfg.protect && (idx < PROT_LIM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx <= '0;
         cfg <= '0;
         pol <= '0;
      end else if (wr) begin
         case (sel)
            SEL_INDEX: idx <= wdata[IDX_W-1:0];
            SEL_POL:   pol <= wdata[7:6];
            SEL_DATA: begin
               if (!locked) begin
                  case (idx)
                     IX_HTOT:  cfg.h_total  <= wdata;
                     IX_HDEND: cfg.h_de_end <= wdata;
                     IX_HBST:  cfg.h_bl_st  <= wdata;
                     IX_HBEND: cfg.h_bl_end[4:0] <= wdata[4:0];
                     IX_HSST:  cfg.h_sy_st  <= wdata;
                     IX_HSEND: begin
                        cfg.h_bl_end[5] <= wdata[7];
                        cfg.h_sy_end    <= wdata[4:0];
                     end
                     IX_VTOT:  cfg.v_total[7:0] <= wdata;
                     IX_OVFL: begin
                        cfg.v_total[8]  <= wdata[0];
                        cfg.v_de_end[8] <= wdata[1];
                        cfg.v_sy_st[8]  <= wdata[2];
                        cfg.v_bl_st[8]  <= wdata[3];
                        cfg.v_total[9]  <= wdata[5];
                        cfg.v_de_end[9] <= wdata[6];
                        cfg.v_sy_st[9]  <= wdata[7];
                     end
                     IX_VHIGH: cfg.v_bl_st[9] <= wdata[5];
                     IX_VSST:  cfg.v_sy_st[7:0] <= wdata;
                     IX_VSEND: begin
                        cfg.protect   <= wdata[7];
                        cfg.irq_off   <= wdata[5];
                        cfg.irq_clr_n <= wdata[4];
                        cfg.v_sy_end  <= wdata[3:0];
                     end
                     IX_VDEND: cfg.v_de_end[7:0] <= wdata;
                     IX_VBST:  cfg.v_bl_st[7:0]  <= wdata;
                     IX_VBEND: cfg.v_bl_end      <= wdata;
                     default: ;
                  endcase
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/crtg_axis.sv
module crtg_axis #(
   parameter int CNT_W   = 9,
   parameter int VAL_W   = 8,
   parameter int BE_W    = 6,
   parameter int SE_W    = 5,
   parameter int TOT_ADJ = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [VAL_W-1:0] total,
   input  logic [VAL_W-1:0] de_end,
   input  logic [VAL_W-1:0] bl_st,
   input  logic [BE_W-1:0]  bl_end,
   input  logic [VAL_W-1:0] sy_st,
   input  logic [SE_W-1:0]  sy_end,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap,
   output logic             de,
   output logic             blank,
   output logic             sync
);
   localparam logic [CNT_W-1:0] ADJ = CNT_W'(TOT_ADJ - 1);

   if (CNT_W <= VAL_W) begin : g_bad_cnt
      $error("crtg_axis: counter must be wider than its limit values");
   end
   if ((BE_W > CNT_W) || (SE_W > CNT_W)) begin : g_bad_end
      $error("crtg_axis: end fields wider than the counter");
   end

   logic [CNT_W-1:0] last;
   logic             at_last;
   logic             bl_q;
   logic             sy_q;

   always_comb begin
      last    = CNT_W'(total) + ADJ;
      at_last = (cnt == last);
      wrap    = step & at_last;
      de      = (cnt <= CNT_W'(de_end));
      blank   = (cnt == CNT_W'(bl_st)) | (bl_q & (cnt[BE_W-1:0] != bl_end));
      sync    = (cnt == CNT_W'(sy_st)) | (sy_q & (cnt[SE_W-1:0] != sy_end));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt  <= '0;
         bl_q <= 1'b0;
         sy_q <= 1'b0;
      end else if (step) begin
         cnt  <= at_last ? '0 : cnt + 1'b1;
         bl_q <= blank;
         sy_q <= sync;
      end
   end
endmodule

// File: rtl/crtg_timing.sv
module crtg_timing
   import crtg_pkg::*;
#(
   parameter int H_CNT_W = 9,
   parameter int V_CNT_W = 11,
   parameter bit OUT_REG = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_wr,
   input  logic [1:0] bus_sel,
   input  logic [7:0] bus_wdata,
   output logic       disp_en_o,
   output logic       blank_o,
   output logic       hsync_o,
   output logic       vsync_o,
   output logic       irq_o,
   output logic [7:0] status_o
);
   if (H_CNT_W < REG_W + 1) begin : g_bad_h
      $error("crtg_timing: H_CNT_W too small for total + adjustment");
   end
   if (V_CNT_W < VVAL_W + 1) begin : g_bad_v
      $error("crtg_timing: V_CNT_W too small for total + adjustment");
   end

   crtg_cfg_t        cfg;
   logic [IDX_W-1:0] idx;
   logic [1:0]       pol;
   logic [H_CNT_W-1:0] hcnt;
   logic [V_CNT_W-1:0] vcnt;
   logic hwrap, vwrap, h_de, v_de, h_bl, v_bl, h_sy, v_sy;
   logic vsy_d, pend;
   logic disp_c, blank_c, hs_c, vs_c;
   logic [7:0] status_c;

   crtg_regfile u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(bus_sel), .wdata(bus_wdata),
      .cfg(cfg), .idx(idx), .pol(pol)
   );

   crtg_axis #(
      .CNT_W(H_CNT_W), .VAL_W(REG_W), .BE_W(HBE_W), .SE_W(HSE_W), .TOT_ADJ(H_ADJ)
   ) u_hor (
      .clk(clk), .rst_n(rst_n), .step(1'b1),
      .total(cfg.h_total), .de_end(cfg.h_de_end),
      .bl_st(cfg.h_bl_st), .bl_end(cfg.h_bl_end),
      .sy_st(cfg.h_sy_st), .sy_end(cfg.h_sy_end),
      .cnt(hcnt), .wrap(hwrap), .de(h_de), .blank(h_bl), .sync(h_sy)
   );

   crtg_axis #(
      .CNT_W(V_CNT_W), .VAL_W(VVAL_W), .BE_W(VBE_W), .SE_W(VSE_W), .TOT_ADJ(V_ADJ)
   ) u_ver (
      .clk(clk), .rst_n(rst_n), .step(hwrap),
      .total(cfg.v_total), .de_end(cfg.v_de_end),
      .bl_st(cfg.v_bl_st), .bl_end(cfg.v_bl_end),
      .sy_st(cfg.v_sy_st), .sy_end(cfg.v_sy_end),
      .cnt(vcnt), .wrap(vwrap), .de(v_de), .blank(v_bl), .sync(v_sy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vsy_d <= 1'b0;
         pend  <= 1'b0;
      end else begin
         vsy_d <= v_sy;
         if (!cfg.irq_clr_n)
            pend <= 1'b0;
         else if (v_sy && !vsy_d && !cfg.irq_off)
            pend <= 1'b1;
      end
   end

   always_comb begin
      disp_c   = h_de & v_de;
      blank_c  = h_bl | v_bl;
      hs_c     = h_sy ^ pol[0];
      vs_c     = v_sy ^ pol[1];
      status_c = {pend, 3'b000, v_sy, 2'b00, h_sy};
   end

   if (OUT_REG) begin : g_oreg
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            disp_en_o <= 1'b0;
            blank_o   <= 1'b0;
            hsync_o   <= 1'b0;
            vsync_o   <= 1'b0;
            irq_o     <= 1'b0;
            status_o  <= '0;
         end else begin
            disp_en_o <= disp_c;
            blank_o   <= blank_c;
            hsync_o   <= hs_c;
            vsync_o   <= vs_c;
            irq_o     <= status_c[7];
            status_o  <= status_c;
         end
      end
   end else begin : g_ocomb
      always_comb begin
         disp_en_o = disp_c;
         blank_o   = blank_c;
         hsync_o   = hs_c;
         vsync_o   = vs_c;
         irq_o     = status_c[7];
         status_o  = status_c;
      end
   end
endmodule

// File: rtl/crtg_timing_chk.sv
module crtg_timing_chk #(
   parameter int H_CNT_W = 9,
   parameter int V_CNT_W = 11
) (
   input logic               clk,
   input logic               rst_n,
   input logic               bus_wr,
   input logic [1:0]         bus_sel,
   input logic [4:0]         idx,
   input logic               protect,
   input logic [7:0]         htot,
   input logic [H_CNT_W-1:0] hcnt,
   input logic               hwrap,
   input logic [V_CNT_W-1:0] vcnt,
   input logic               vwrap,
   input logic               vblank,
   input logic               vsync,
   input logic               clr_n,
   input logic               pend,
   input logic               irq_o,
   input logic [7:0]         status_o
);
   logic [H_CNT_W-1:0] h_last;
   always_comb h_last = H_CNT_W'(htot) + H_CNT_W'(4);

   p_hstep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hcnt != h_last) |=> (hcnt == $past(hcnt) + 1'b1));
   p_hwrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (hcnt == h_last) |=> (hcnt == '0));
   p_vhold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !hwrap |=> $stable(vcnt));
   p_vwrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vwrap |=> (vcnt == '0));
   p_vblank_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwrap && !bus_wr) |=> $stable(vblank));
   p_vsync_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!hwrap && !bus_wr) |=> $stable(vsync));
   p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (protect && bus_wr && bus_sel == 2'd1 && idx < 5'd8) |=> $stable(htot));
   p_irq_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |=> !pend);
   p_irq_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
      status_o[7] == irq_o);
endmodule

bind crtg_timing crtg_timing_chk #(.H_CNT_W(H_CNT_W), .V_CNT_W(V_CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
   .idx(idx), .protect(cfg.protect), .htot(cfg.h_total),
   .hcnt(hcnt), .hwrap(hwrap), .vcnt(vcnt), .vwrap(vwrap),
   .vblank(v_bl), .vsync(v_sy), .clr_n(cfg.irq_clr_n), .pend(pend),
   .irq_o(irq_o), .status_o(status_o)
);

// File: tb/test_crtg_timing.sv
module test_crtg_timing;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_wr = 1'b0;
   logic [1:0] bus_sel = 2'd3;
   logic [7:0] bus_wdata = 8'd0;
   logic disp_en_o, blank_o, hsync_o, vsync_o, irq_o;
   logic [7:0] status_o;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;
   bit chk_en = 1'b0;

   always #5 clk = ~clk;

   crtg_timing i_crtg_timing (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
      .bus_wdata(bus_wdata), .disp_en_o(disp_en_o), .blank_o(blank_o),
      .hsync_o(hsync_o), .vsync_o(vsync_o), .irq_o(irq_o), .status_o(status_o)
   );

   typedef struct packed {
      logic [7:0] ht, hde, hbs;
      logic [5:0] hbe;
      logic [7:0] hrs;
      logic [4:0] hre;
      logic [9:0] vt, vde, vbs, vrs;
      logic [7:0] vbe;
      logic [3:0] vre;
      logic       ioff;
      logic [1:0] pol;
   } tcfg_t;

   localparam tcfg_t CFGS [3] = '{
      '{8'd5, 8'd5, 8'd6, 6'd9, 8'd7, 5'd8, 10'd4, 10'd2, 10'd3, 10'd4, 8'd5, 4'd5, 1'b0, 2'b00},
      '{8'd70, 8'd63, 8'd64, 6'h2A, 8'd66, 5'd5, 10'h100, 10'h0FF, 10'h100, 10'h101, 8'd2, 4'd3, 1'b0, 2'b11},
      '{8'd5, 8'd3, 8'd4, 6'd1, 8'd8, 5'd0, 10'h201, 10'h1FF, 10'h200, 10'h202, 8'd4, 4'd7, 1'b1, 2'b10}
   };

   // shadow registers built from the requirement text
   logic [4:0] s_idx;
   logic [7:0] s_ht, s_hde, s_hbs, s_hrs, s_vbe;
   logic [5:0] s_hbe;
   logic [4:0] s_hre;
   logic [9:0] s_vt, s_vde, s_vbs, s_vrs;
   logic [3:0] s_vre;
   logic s_prot, s_ioff, s_iclr;
   logic [1:0] s_pol;
   // reference state
   logic [8:0] m_h;
   logic [10:0] m_v;
   logic m_hb, m_hs, m_vb, m_vs, m_vd, m_p;
   logic e_hwrap, e_hb, e_hs, e_vb, e_vs, e_de;
   logic [7:0] e_st;

   always_comb begin
      e_hwrap = (m_h == {1'b0, s_ht} + 9'd4);
      e_hb = (m_h == {1'b0, s_hbs}) | (m_hb & (m_h[5:0] != s_hbe));
      e_hs = (m_h == {1'b0, s_hrs}) | (m_hs & (m_h[4:0] != s_hre));
      e_vb = (m_v == {1'b0, s_vbs}) | (m_vb & (m_v[7:0] != s_vbe));
      e_vs = (m_v == {1'b0, s_vrs}) | (m_vs & (m_v[3:0] != s_vre));
      e_de = (m_h <= {1'b0, s_hde}) && (m_v <= {1'b0, s_vde});
      e_st = {m_p, 3'b000, e_vs, 2'b00, e_hs};
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         s_idx <= '0; s_ht <= '0; s_hde <= '0; s_hbs <= '0; s_hrs <= '0; s_vbe <= '0;
         s_hbe <= '0; s_hre <= '0; s_vt <= '0; s_vde <= '0; s_vbs <= '0; s_vrs <= '0;
         s_vre <= '0; s_prot <= 1'b0; s_ioff <= 1'b0; s_iclr <= 1'b0; s_pol <= '0;
         m_h <= '0; m_v <= '0; m_hb <= 1'b0; m_hs <= 1'b0; m_vb <= 1'b0; m_vs <= 1'b0;
         m_vd <= 1'b0; m_p <= 1'b0;
      end else begin
         if (bus_wr) begin
            if (bus_sel == 2'd0) s_idx <= bus_wdata[4:0];
            else if (bus_sel == 2'd2) s_pol <= bus_wdata[7:6];
            else if (bus_sel == 2'd1 && !(s_prot && s_idx < 5'd8)) begin
               case (s_idx)
                  5'd0: s_ht <= bus_wdata;
                  5'd1: s_hde <= bus_wdata;
                  5'd2: s_hbs <= bus_wdata;
                  5'd3: s_hbe[4:0] <= bus_wdata[4:0];
                  5'd4: s_hrs <= bus_wdata;
                  5'd5: begin s_hbe[5] <= bus_wdata[7]; s_hre <= bus_wdata[4:0]; end
                  5'd6: s_vt[7:0] <= bus_wdata;
                  5'd7: begin
                     s_vt[8] <= bus_wdata[0]; s_vde[8] <= bus_wdata[1];
                     s_vrs[8] <= bus_wdata[2]; s_vbs[8] <= bus_wdata[3];
                     s_vt[9] <= bus_wdata[5]; s_vde[9] <= bus_wdata[6];
                     s_vrs[9] <= bus_wdata[7];
                  end
                  5'd9: s_vbs[9] <= bus_wdata[5];
                  5'd16: s_vrs[7:0] <= bus_wdata;
                  5'd17: begin
                     s_prot <= bus_wdata[7]; s_ioff <= bus_wdata[5];
                     s_iclr <= bus_wdata[4]; s_vre <= bus_wdata[3:0];
                  end
                  5'd18: s_vde[7:0] <= bus_wdata;
                  5'd21: s_vbs[7:0] <= bus_wdata;
                  5'd22: s_vbe <= bus_wdata;
                  default: ;
               endcase
            end
         end
         m_h <= e_hwrap ? 9'd0 : m_h + 9'd1;
         m_hb <= e_hb;
         m_hs <= e_hs;
         if (e_hwrap) begin
            m_v <= (m_v == {1'b0, s_vt} + 11'd1) ? 11'd0 : m_v + 11'd1;
            m_vb <= e_vb;
            m_vs <= e_vs;
         end
         m_vd <= e_vs;
         if (!s_iclr) m_p <= 1'b0;
         else if (e_vs && !m_vd && !s_ioff) m_p <= 1'b1;
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && chk_en && !done) begin
         check(disp_en_o == e_de, "R2 display enable", int'(disp_en_o), int'(e_de));
         check(blank_o == (e_hb | e_vb), "R3 R6 R12 blank", int'(blank_o), int'(e_hb | e_vb));
         check(hsync_o == (e_hs ^ s_pol[0]), "R4 R11 hsync", int'(hsync_o), int'(e_hs ^ s_pol[0]));
         check(vsync_o == (e_vs ^ s_pol[1]), "R7 R11 vsync", int'(vsync_o), int'(e_vs ^ s_pol[1]));
         check(status_o == e_st, "R10 status", int'(status_o), int'(e_st));
         check(irq_o == m_p, "R9 irq", int'(irq_o), int'(m_p));
      end
   end

   task automatic bus(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_sel = s; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_sel = 2'd3;
   endtask

   task automatic wreg(input logic [4:0] ix, input logic [7:0] d);
      bus(2'd0, {3'b000, ix});
      bus(2'd1, d);
   endtask

   task automatic prog(input tcfg_t c);
      wreg(5'd17, {1'b0, 1'b0, c.ioff, 1'b0, c.vre});
      wreg(5'd0, c.ht);
      wreg(5'd1, c.hde);
      wreg(5'd2, c.hbs);
      wreg(5'd3, {3'b000, c.hbe[4:0]});
      wreg(5'd4, c.hrs);
      wreg(5'd5, {c.hbe[5], 2'b00, c.hre});
      wreg(5'd6, c.vt[7:0]);
      wreg(5'd7, {c.vrs[9], c.vde[9], c.vt[9], 1'b0, c.vbs[8], c.vrs[8], c.vde[8], c.vt[8]});
      wreg(5'd9, {2'b00, c.vbs[9], 5'b00000});
      wreg(5'd16, c.vrs[7:0]);
      wreg(5'd18, c.vde[7:0]);
      wreg(5'd21, c.vbs[7:0]);
      wreg(5'd22, c.vbe);
      bus(2'd2, {c.pol, 6'b000000});
      wreg(5'd17, {1'b0, 1'b0, c.ioff, 1'b1, c.vre});
   endtask

   task automatic period(input int b, output int n);
      logic prev;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         if (status_o[b] && !prev) break;
         prev = status_o[b];
      end
      n = 0;
      prev = 1'b1;
      forever begin
         @(negedge clk);
         n++;
         if (status_o[b] && !prev) break;
         prev = status_o[b];
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   initial begin
      int n;
      int exp;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      chk_en = 1'b1;
      @(negedge clk);
      check(irq_o == 1'b0, "R9 reset irq", int'(irq_o), 0);
      check(status_o[7] == 1'b0, "R12 reset status flag", int'(status_o[7]), 0);

      foreach (CFGS[i]) begin
         prog(CFGS[i]);
         exp = (int'(CFGS[i].vt) + 2) * (int'(CFGS[i].ht) + 5);
         repeat (2 * exp + 600) @(negedge clk);
         period(0, n);
         check(n == int'(CFGS[i].ht) + 5, "R1 line length", n, int'(CFGS[i].ht) + 5);
         period(3, n);
         check(n == exp, "R5 frame length", n, exp);
         check(irq_o == !CFGS[i].ioff, "R9 flag after frame", int'(irq_o), int'(!CFGS[i].ioff));
      end

      // directed: clear, protect
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      prog(CFGS[0]);
      repeat (200) @(negedge clk);
      check(irq_o == 1'b1, "R9 flag set", int'(irq_o), 1);
      wreg(5'd17, {1'b0, 1'b0, 1'b0, 1'b0, CFGS[0].vre});
      @(negedge clk);
      check(irq_o == 1'b0, "R9 flag cleared", int'(irq_o), 0);
      wreg(5'd17, {1'b1, 1'b0, 1'b0, 1'b1, CFGS[0].vre});
      wreg(5'd0, 8'd20);
      wreg(5'd22, 8'd4);
      repeat (30) @(negedge clk);
      period(0, n);
      check(n == 10, "R8 protected line length", n, 10);
      wreg(5'd17, {1'b0, 1'b0, 1'b0, 1'b1, CFGS[0].vre});
      wreg(5'd0, 8'd9);
      repeat (30) @(negedge clk);
      period(0, n);
      check(n == 14, "R8 unprotected line length", n, 14);
      repeat (20) @(negedge clk);
      finish_run();
   end
endmodule